// File: doc/BRIEF.md
# Modem-Line Hardware Flow Control

This block gives one serial channel automatic flow control on its two modem handshake lines. On the receive side it watches the receive buffer fill count. It drives the active-low request-to-send line inactive once the count climbs to a halt level. It drives the line active again only after the count has drained down to a separate, lower resume level. Both levels are 4-bit fields counted in units of four entries, so a 64-entry buffer is covered. When automatic control is off, a manual control bit sets the line instead.

On the transmit side, the active-low clear-to-send input first passes through a synchroniser. The result then decides whether the serializer may begin its next character. While no character is in flight, the permit follows the synchronised line. While a character is in flight, the permit is frozen, and the decision is re-sampled only at the strobe that marks the middle of the last stop bit.

Both lines produce a one-cycle event for the interrupt logic whenever either one moves from active to inactive.

Top module: `modem_flow_ctrl`

## Requirements
- R1: While reset is held, `rts_n` is 1, `flow_evt` is 0, and with `auto_cts_en` = 1 `tx_permit` is 0 because the synchronised line resets to inactive.
- R2: With `auto_rts_en` = 1 and `thr_halt` nonzero, `rts_n` becomes 1 one clock after `rx_level` is at least 4 × `thr_halt`.
- R3: Once driven inactive by R2, `rts_n` stays 1 while `rx_level` is greater than 4 × `thr_resume`. It returns to 0 one clock after the level is at or below that value.
- R4: With `auto_rts_en` = 1 and `thr_halt` = 0, `rts_n` stays 0 at every fill level.
- R5: With `auto_rts_en` = 0, `rts_n` equals the inverse of `rts_manual`, one clock later.
- R6: With `auto_cts_en` = 1 and `tx_busy` = 0, `tx_permit` equals the inverse of `cts_n_async` with a delay of three clocks (two synchroniser stages plus the permit register).
- R7: With `auto_cts_en` = 1, `tx_busy` = 1 and no `tx_mid_stop` strobe, `tx_permit` holds its value whatever `cts_n_async` does.
- R8: On a clock where `tx_mid_stop` is 1, the permit register loads the inverse of the synchronised CTS, and `tx_permit` shows it one clock later.
- R9: With `auto_cts_en` = 0, `tx_permit` is 1.
- R10: `flow_evt` is a single-cycle pulse. It is issued in the same cycle that `rts_n` rises, or two clocks after `cts_n_async` rises. Falling edges of either line produce no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_level | input | LEVEL_W (7) | Receive buffer fill count |
| thr_halt | input | THR_W (4) | Halt level in units of four entries, 0 disables halting |
| thr_resume | input | THR_W (4) | Resume level in units of four entries |
| auto_rts_en | input | 1 | Automatic request-to-send enable |
| auto_cts_en | input | 1 | Automatic clear-to-send qualification enable |
| rts_manual | input | 1 | Manual request-to-send, 1 drives the line active |
| cts_n_async | input | 1 | Clear-to-send line, active low, asynchronous |
| tx_busy | input | 1 | A character is in flight in the serializer |
| tx_mid_stop | input | 1 | Strobe at the middle of the last stop bit |
| rts_n | output | 1 | Request-to-send line, active low |
| tx_permit | output | 1 | Serializer may start the next character |
| flow_evt | output | 1 | One-cycle active-to-inactive event |

## Verification
The receive side is swept over every pair of a nonzero halt level and a lower resume level. Each sweep runs a full ramp of fill counts up to 64 and back down to zero. The rising ramp pins the exact count at which the line goes inactive, and the falling ramp shows that the line stays inactive down to the resume level and not just to the halt level. The transmit side is driven with the line falling and rising while the serializer is idle, which measures the synchroniser delay and the event pulse. It is then driven with the line changing during a character in flight, which separates holding the permit from re-sampling it at the stop-bit strobe. Manual mode, the zero halt level and disabled CTS qualification are each tried separately.

// File: rtl/mfc_pkg.sv
package mfc_pkg;

  // Hysteresis step: a zero halt field keeps the line active; otherwise the
  // held state is entered at the halt level and kept above the resume level.
  function automatic logic next_hold(input logic held, input logic halt_on,
                                     input logic at_halt, input logic over_resume);
    if (!halt_on) return 1'b0;
    return held ? over_resume : at_halt;
  endfunction

  // Active-to-inactive detection for an active-low line.
  function automatic logic goes_inactive(input logic now_n, input logic next_n);
    return next_n & ~now_n;
  endfunction

endpackage

// File: rtl/mfc_rts_hyst.sv
module mfc_rts_hyst #(
  parameter int LEVEL_W    = 7,
  parameter int THR_W      = 4,
  parameter int UNIT_SHIFT = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [LEVEL_W-1:0] rx_level,
  input  logic [THR_W-1:0]   thr_halt,
  input  logic [THR_W-1:0]   thr_resume,
  input  logic               auto_en,
  input  logic               manual,
  output logic               rts_n,
  output logic               rts_rise
);
  import mfc_pkg::*;

  logic [LEVEL_W-1:0] halt_lvl;
  logic [LEVEL_W-1:0] resume_lvl;
  logic               held_q, held_d;
  logic               rts_n_q, rts_n_d;

  assign halt_lvl   = LEVEL_W'(thr_halt) << UNIT_SHIFT;
  assign resume_lvl = LEVEL_W'(thr_resume) << UNIT_SHIFT;

  assign held_d  = next_hold(held_q, thr_halt != '0,
                             rx_level >= halt_lvl, rx_level > resume_lvl);
  assign rts_n_d = auto_en ? held_d : ~manual;
  assign rts_rise = goes_inactive(rts_n_q, rts_n_d);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_q  <= 1'b0;
      rts_n_q <= 1'b1;
    end else begin
      held_q  <= held_d;
      rts_n_q <= rts_n_d;
    end
  end

  assign rts_n = rts_n_q;
endmodule

// File: rtl/mfc_cts_gate.sv
module mfc_cts_gate #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cts_n_async,
  input  logic auto_en,
  input  logic tx_busy,
  input  logic tx_mid_stop,
  output logic cts_sync,
  output logic cts_rise,
  output logic tx_permit
);
  import mfc_pkg::*;

  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   go_q;

  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) sync_q[s] <= 1'b1;
          else        sync_q[s] <= cts_n_async;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) sync_q[s] <= 1'b1;
          else        sync_q[s] <= sync_q[s-1];
        end
      end
    end
  endgenerate

  assign cts_sync = sync_q[LAST];
  assign cts_rise = goes_inactive(sync_q[LAST], sync_q[LAST-1]);

  // Decision point: continuously while idle, only at mid-stop while busy.
  always_ff @(posedge clk) begin
    if (!rst_n)                      go_q <= 1'b0;
    else if (!tx_busy || tx_mid_stop) go_q <= ~cts_sync;
  end

  assign tx_permit = ~auto_en | go_q;
endmodule

// File: rtl/modem_flow_ctrl.sv
module modem_flow_ctrl #(
  parameter int LEVEL_W     = 7,
  parameter int THR_W       = 4,
  parameter int UNIT_SHIFT  = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [LEVEL_W-1:0] rx_level,
  input  logic [THR_W-1:0]   thr_halt,
  input  logic [THR_W-1:0]   thr_resume,
  input  logic               auto_rts_en,
  input  logic               auto_cts_en,
  input  logic               rts_manual,
  input  logic               cts_n_async,
  input  logic               tx_busy,
  input  logic               tx_mid_stop,
  output logic               rts_n,
  output logic               tx_permit,
  output logic               flow_evt
);
  logic rts_rise;
  logic cts_rise;
  logic cts_sync;
  logic evt_q;

  mfc_rts_hyst #(.LEVEL_W(LEVEL_W), .THR_W(THR_W), .UNIT_SHIFT(UNIT_SHIFT)) u_rts (
    .clk(clk), .rst_n(rst_n), .rx_level(rx_level), .thr_halt(thr_halt),
    .thr_resume(thr_resume), .auto_en(auto_rts_en), .manual(rts_manual),
    .rts_n(rts_n), .rts_rise(rts_rise)
  );

  mfc_cts_gate #(.SYNC_STAGES(SYNC_STAGES)) u_cts (
    .clk(clk), .rst_n(rst_n), .cts_n_async(cts_n_async), .auto_en(auto_cts_en),
    .tx_busy(tx_busy), .tx_mid_stop(tx_mid_stop), .cts_sync(cts_sync),
    .cts_rise(cts_rise), .tx_permit(tx_permit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) evt_q <= 1'b0;
    else        evt_q <= rts_rise | cts_rise;
  end

  assign flow_evt = evt_q;
endmodule

// File: rtl/mfc_checker.sv
module mfc_checker #(
  parameter int LEVEL_W    = 7,
  parameter int THR_W      = 4,
  parameter int UNIT_SHIFT = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic [LEVEL_W-1:0] rx_level,
  input logic [THR_W-1:0]   thr_halt,
  input logic [THR_W-1:0]   thr_resume,
  input logic               auto_rts_en,
  input logic               auto_cts_en,
  input logic               rts_manual,
  input logic               tx_busy,
  input logic               tx_mid_stop,
  input logic               rts_n,
  input logic               tx_permit,
  input logic               flow_evt,
  input logic               cts_sync
);
  localparam int UNIT = 1 << UNIT_SHIFT;

  logic [LEVEL_W-1:0] halt_lvl;
  logic [LEVEL_W-1:0] resume_lvl;
  assign halt_lvl   = LEVEL_W'(thr_halt) * LEVEL_W'(UNIT);
  assign resume_lvl = LEVEL_W'(thr_resume) * LEVEL_W'(UNIT);

  assert_halt_reached_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_rts_en && thr_halt != '0 && rx_level >= halt_lvl && rx_level > resume_lvl) |=> rts_n);

  assert_hold_above_resume_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_rts_en && $past(auto_rts_en) && thr_halt != '0 && rts_n && rx_level > resume_lvl) |=> rts_n);

  assert_zero_halt_active_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_rts_en && thr_halt == '0) |=> !rts_n);

  assert_manual_rts_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_rts_en |=> (rts_n != $past(rts_manual)));

  assert_busy_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_cts_en && $past(auto_cts_en && tx_busy && !tx_mid_stop)) |-> $stable(tx_permit));

  assert_mid_stop_sample_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_cts_en && $past(auto_cts_en && tx_mid_stop)) |-> (tx_permit == !$past(cts_sync)));

  assert_no_qual_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_cts_en |-> tx_permit);

  assert_rts_event_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rts_n) |-> flow_evt);

  assert_event_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    flow_evt |=> !flow_evt || $rose(rts_n));
endmodule

bind modem_flow_ctrl mfc_checker #(
  .LEVEL_W(LEVEL_W), .THR_W(THR_W), .UNIT_SHIFT(UNIT_SHIFT)
) i_mfc_checker (
  .clk(clk), .rst_n(rst_n), .rx_level(rx_level), .thr_halt(thr_halt),
  .thr_resume(thr_resume), .auto_rts_en(auto_rts_en), .auto_cts_en(auto_cts_en),
  .rts_manual(rts_manual), .tx_busy(tx_busy), .tx_mid_stop(tx_mid_stop),
  .rts_n(rts_n), .tx_permit(tx_permit), .flow_evt(flow_evt), .cts_sync(cts_sync)
);

// File: tb/test_modem_flow_ctrl.sv
module test_modem_flow_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] rx_level = '0;
  logic [3:0] thr_halt = '0;
  logic [3:0] thr_resume = '0;
  logic       auto_rts_en = 1'b0;
  logic       auto_cts_en = 1'b1;
  logic       rts_manual = 1'b0;
  logic       cts_n_async = 1'b1;
  logic       tx_busy = 1'b0;
  logic       tx_mid_stop = 1'b0;
  logic       rts_n, tx_permit, flow_evt;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  modem_flow_ctrl i_modem_flow_ctrl (
    .clk(clk), .rst_n(rst_n), .rx_level(rx_level), .thr_halt(thr_halt),
    .thr_resume(thr_resume), .auto_rts_en(auto_rts_en), .auto_cts_en(auto_cts_en),
    .rts_manual(rts_manual), .cts_n_async(cts_n_async), .tx_busy(tx_busy),
    .tx_mid_stop(tx_mid_stop), .rts_n(rts_n), .tx_permit(tx_permit), .flow_evt(flow_evt)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    repeat (3) step();
    chk("R1 rts_n", rts_n, 1'b1);
    chk("R1 flow_evt", flow_evt, 1'b0);
    chk("R1 tx_permit", tx_permit, 1'b0);
    rst_n = 1'b1;
    auto_rts_en = 1'b1;
    auto_cts_en = 1'b0;
    step();
    chk("R9 permit with qualification off", tx_permit, 1'b1);

    // R2 / R3 / R10: every nonzero halt with every lower resume, full ramps
    for (int h = 1; h < 16; h++) begin
      for (int r = 0; r < h; r++) begin
        rx_level = '0;
        step();
        thr_halt = 4'(h);
        thr_resume = 4'(r);
        step();
        chk("R3 released at empty", rts_n, 1'b0);
        for (int lv = 0; lv <= 64; lv++) begin
          rx_level = 7'(lv);
          step();
          chk("R2 ramp up", rts_n, lv >= 4 * h);
          chk("R10 event at halt", flow_evt, lv == 4 * h);
        end
        for (int lv = 64; lv >= 0; lv--) begin
          rx_level = 7'(lv);
          step();
          chk("R3 ramp down", rts_n, lv > 4 * r);
          chk("R10 no event on fall", flow_evt, 1'b0);
        end
      end
    end

    // R4: zero halt field
    thr_halt = '0;
    thr_resume = 4'd3;
    for (int lv = 0; lv <= 64; lv += 8) begin
      rx_level = 7'(lv);
      step();
      chk("R4 zero halt", rts_n, 1'b0);
    end
    rx_level = '0;

    // R5: manual control
    auto_rts_en = 1'b0;
    rts_manual = 1'b0;
    step();
    chk("R5 manual 0", rts_n, 1'b1);
    chk("R10 event on manual rise", flow_evt, 1'b1);
    step();
    chk("R10 pulse one cycle", flow_evt, 1'b0);
    rts_manual = 1'b1;
    step();
    chk("R5 manual 1", rts_n, 1'b0);
    chk("R10 no event on fall", flow_evt, 1'b0);

    // R6: idle path latency
    auto_cts_en = 1'b1;
    step();
    chk("R6 permit starts off", tx_permit, 1'b0);
    cts_n_async = 1'b0;
    step();
    chk("R6 after 1", tx_permit, 1'b0);
    step();
    chk("R6 after 2", tx_permit, 1'b0);
    chk("R10 no event on CTS fall", flow_evt, 1'b0);
    step();
    chk("R6 after 3", tx_permit, 1'b1);
    cts_n_async = 1'b1;
    step();
    chk("R10 not yet", flow_evt, 1'b0);
    step();
    chk("R10 CTS rise event", flow_evt, 1'b1);
    chk("R6 still on", tx_permit, 1'b1);
    step();
    chk("R6 off after 3", tx_permit, 1'b0);
    chk("R10 pulse ends", flow_evt, 1'b0);

    // R7 / R8: character in flight
    cts_n_async = 1'b0;
    repeat (3) step();
    chk("R6 permit on", tx_permit, 1'b1);
    tx_busy = 1'b1;
    cts_n_async = 1'b1;
    for (int i = 0; i < 5; i++) begin
      step();
      chk("R7 hold on", tx_permit, 1'b1);
    end
    tx_mid_stop = 1'b1;
    step();
    tx_mid_stop = 1'b0;
    chk("R8 sample inactive", tx_permit, 1'b0);
    cts_n_async = 1'b0;
    for (int i = 0; i < 5; i++) begin
      step();
      chk("R7 hold off", tx_permit, 1'b0);
    end
    tx_mid_stop = 1'b1;
    step();
    tx_mid_stop = 1'b0;
    chk("R8 sample active", tx_permit, 1'b1);
    tx_busy = 1'b0;

    // R9: qualification off while line inactive
    cts_n_async = 1'b1;
    repeat (4) step();
    chk("R6 idle off", tx_permit, 1'b0);
    auto_cts_en = 1'b0;
    step();
    chk("R9 permit forced", tx_permit, 1'b1);

    finish_run();
  end
endmodule